// File: doc/BRIEF.md
# Halfband 2x Interpolator

This block doubles the sample rate of a stream of 12-bit two's-complement samples. Each accepted input sample yields one output pair. The two members of the pair are the two phases of a 23-tap symmetric halfband low-pass filter. No zero samples are ever stored or multiplied, because the filter is split into polyphase form. The first phase is a 12-coefficient symmetric FIR, which pre-adds mirrored sample pairs and so needs only six multiplies. The second phase is the input delayed to the centre-tap position. Both phases are scaled back by 2^12, rounded and clamped to 12 bits.

A sample is taken on any clock edge where the enable input is high. The pair is delivered side by side together with a one-cycle valid strobe. A downstream consumer can drive the pair out on a clock that runs twice as fast, or step through it in two cycles. Several copies can be chained to raise the overall rate by 4x or 8x.

Top module: `hbi_interp`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and both output words are 0. Reset also clears the sample history to zero.
- R2: `out_valid` is high for exactly one cycle for each accepted sample. It is seen after the second rising edge, counting the edge that took the sample.
- R3: `out_second` equals the sample accepted five steps before the current one. It is 0 while fewer than six samples have been accepted since reset.
- R4: `out_first` equals the sum of g[j]·x[m−j] for j = 0..11, divided by 4096 with round-half-up: (sum + 2048) shifted arithmetically right by 12. Here x[m] is the newest sample and g = −2, 17, −75, 238, −660, 2530, 2530, −660, 238, −75, 17, −2.
- R5: A rounded result above 2047 is output as 2047. One below −2048 is output as −2048. Full-scale steps in either direction reach these limits.
- R6: On a cycle with `in_en` low, `in_data` is ignored. The history does not shift, and when `out_valid` is low the output words keep their previous values.
- R7: A reset in the middle of a stream clears all history. The outputs that follow are the same as for a fresh start.
- R8: A constant input c, held for at least 12 steps, gives c on both phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_en | input | 1 | Accept `in_data` on this edge |
| in_data | input | 12 | Input sample, two's complement |
| out_valid | output | 1 | Output pair is new this cycle |
| out_first | output | 12 | Earlier output of the pair (filtered phase) |
| out_second | output | 12 | Later output of the pair (centre-tap phase) |

## Verification
Rounding and saturation both act on the filtered phase in the same cycle. A full-scale step from −2048 to 2047, and its mirror, pushes the accumulator past the 12-bit range, so the rounding offset is added to a value that must then be clamped. The bench compares every such output with a zero-stuff-and-convolve model and also requires that both rails are actually reached. A second case sends garbage data on cycles where the enable is low. In those cycles the output hold and the sample history are judged together, by comparing the next valid pair with the model.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  // Nonzero coefficients of one polyphase branch
  localparam int HB_PHASE_TAPS = 12;

  // Coefficient for branch tap j; symmetric, so fold onto the lower half
  function automatic int hb_coef(input int j);
    int k;
    k = (j < HB_PHASE_TAPS / 2) ? j : HB_PHASE_TAPS - 1 - j;
    case (k)
      0:       return -2;
      1:       return 17;
      2:       return -75;
      3:       return 238;
      4:       return -660;
      default: return 2530;
    endcase
  endfunction

endpackage

// File: rtl/hbi_tapline.sv
module hbi_tapline #(
  parameter int W     = 12,
  parameter int DEPTH = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic [W-1:0]       din,
  output logic [DEPTH*W-1:0] taps_flat
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)           q <= '0;
      else if (shift_en) begin
        if (g == 0) q <= din;
        else        q <= taps_flat[(g-1)*W +: W];
      end
    end
    assign taps_flat[g*W +: W] = q;
  end

endmodule

// File: rtl/hbi_poly_fir.sv
module hbi_poly_fir #(
  parameter int W     = 12,
  parameter int TAPS  = 12,
  parameter int ACC_W = 28
) (
  input  logic [TAPS*W-1:0]       taps_flat,
  output logic signed [ACC_W-1:0] acc
);

  localparam int PAIRS = TAPS / 2;

  logic [PAIRS*ACC_W-1:0] prod_flat;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic signed [W-1:0]     a;
    logic signed [W-1:0]     b;
    logic signed [W:0]       pre;
    logic signed [ACC_W-1:0] pre_x;
    logic signed [ACC_W-1:0] coef_x;
    assign a      = taps_flat[p*W +: W];
    assign b      = taps_flat[(TAPS-1-p)*W +: W];
    assign pre    = {a[W-1], a} + {b[W-1], b};
    assign pre_x  = ACC_W'(pre);
    assign coef_x = ACC_W'(hbi_pkg::hb_coef(p));
    assign prod_flat[p*ACC_W +: ACC_W] = pre_x * coef_x;
  end

  always_comb begin
    acc = '0;
    for (int p = 0; p < PAIRS; p++) begin
      acc = acc + $signed(prod_flat[p*ACC_W +: ACC_W]);
    end
  end

endmodule

// File: rtl/hbi_round_sat.sv
module hbi_round_sat #(
  parameter int ACC_W = 28,
  parameter int OUT_W = 12,
  parameter int SHIFT = 12
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic signed [OUT_W-1:0] q
);

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(64'sd1 <<< (OUT_W - 1)));

  logic signed [ACC_W-1:0] scaled;

  always_comb begin
    scaled = (acc + HALF) >>> SHIFT;
    if (scaled > MAXV)      q = MAXV[OUT_W-1:0];
    else if (scaled < MINV) q = MINV[OUT_W-1:0];
    else                    q = scaled[OUT_W-1:0];
  end

endmodule

// File: rtl/hbi_interp.sv
module hbi_interp #(
  parameter int DATA_W = 12,
  parameter int ACC_W  = 28,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_en,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_first,
  output logic [DATA_W-1:0] out_second
);

  localparam int TAPS = hbi_pkg::HB_PHASE_TAPS;
  localparam int CTR  = TAPS / 2 - 1;

  logic [TAPS*DATA_W-1:0]  taps_flat;
  logic signed [ACC_W-1:0] fir_acc;
  logic signed [ACC_W-1:0] ctr_acc;
  logic signed [DATA_W-1:0] fir_q;
  logic signed [DATA_W-1:0] ctr_q;
  logic                    taken_d;

  hbi_tapline #(.W(DATA_W), .DEPTH(TAPS)) u_line (
    .clk      (clk),
    .rst      (rst),
    .shift_en (in_en),
    .din      (in_data),
    .taps_flat(taps_flat)
  );

  hbi_poly_fir #(.W(DATA_W), .TAPS(TAPS), .ACC_W(ACC_W)) u_fir (
    .taps_flat(taps_flat),
    .acc      (fir_acc)
  );

  // Centre-tap branch: one tap of weight 2^FRAC_W
  assign ctr_acc = ACC_W'($signed(taps_flat[CTR*DATA_W +: DATA_W])) <<< FRAC_W;

  hbi_round_sat #(.ACC_W(ACC_W), .OUT_W(DATA_W), .SHIFT(FRAC_W)) u_rs_fir (
    .acc(fir_acc),
    .q  (fir_q)
  );

  hbi_round_sat #(.ACC_W(ACC_W), .OUT_W(DATA_W), .SHIFT(FRAC_W)) u_rs_ctr (
    .acc(ctr_acc),
    .q  (ctr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_d    <= 1'b0;
      out_valid  <= 1'b0;
      out_first  <= '0;
      out_second <= '0;
    end else begin
      taken_d   <= in_en;
      out_valid <= taken_d;
      if (taken_d) begin
        out_first  <= fir_q;
        out_second <= ctr_q;
      end
    end
  end

endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              in_en,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_first,
  input logic [DATA_W-1:0] out_second
);

  logic       started;
  logic [2:0] n_taken;

  always_ff @(posedge clk) started <= 1'b1;

  always_ff @(posedge clk) begin
    if (rst)                         n_taken <= '0;
    else if (in_en && n_taken != 3'd7) n_taken <= n_taken + 3'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    (started && $past(rst)) |-> (!out_valid && out_first == '0 && out_second == '0));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_en, 2)));

  assert_warmup_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rst, 2) && $past(n_taken, 2) < 3'd5) |-> (out_second == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> ($stable(out_first) && $stable(out_second)));

endmodule

bind hbi_interp hbi_checker #(.DATA_W(DATA_W)) u_hbi_checker (
  .clk       (clk),
  .rst       (rst),
  .in_en     (in_en),
  .out_valid (out_valid),
  .out_first (out_first),
  .out_second(out_second)
);

// File: tb/tb_hbi_interp.sv
module tb_hbi_interp;

  localparam int W      = 12;
  localparam int IDLE   = 99999;
  localparam int STIM_N = 24;
  localparam int QN     = 512;
  localparam int STIM [STIM_N] = '{100, -300, 2047, IDLE, -2048, 0, 512, IDLE,
                                   IDLE, 1500, -1500, 7, -7, 800, IDLE, -1000,
                                   2000, -2000, 333, IDLE, 0, 0, 64, -64};
  localparam int G [12] = '{-2, 17, -75, 238, -660, 2530, 2530, -660, 238, -75, 17, -2};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_en = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic [W-1:0] out_first;
  logic [W-1:0] out_second;

  int    nchk = 0, nfail = 0;
  int    hist [12];
  int    exp_a [QN], exp_b [QN];
  string exp_t [QN];
  int    wr = 0, rd = 0;
  string tag = "R4";
  int    hi_seen = 0, lo_seen = 0;
  logic  en_h1 = 1'b0;
  logic [W-1:0] prev_a = '0, prev_b = '0;

  hbi_interp dut (
    .clk(clk), .rst(rst), .in_en(in_en), .in_data(in_data),
    .out_valid(out_valid), .out_first(out_first), .out_second(out_second)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 12; i++) hist[i] = 0;
  endtask

  task automatic step(input int d);
    int acc, r;
    @(negedge clk);
    in_en   <= 1'b1;
    in_data <= W'(d);
    for (int i = 11; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = d;
    acc = 0;
    for (int j = 0; j < 12; j++) acc += G[j] * hist[j];
    r = (acc + 2048) >>> 12;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    exp_a[wr % QN] = r;
    exp_b[wr % QN] = hist[5];
    exp_t[wr % QN] = tag;
    wr++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_en   <= 1'b0;
      in_data <= W'(12'hA5A ^ (i * 377));
    end
  endtask

  // Output monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      en_h1  = 1'b0;
      prev_a = out_first;
      prev_b = out_second;
    end else begin
      chk(out_valid == en_h1, "R2 valid timing", int'(out_valid), int'(en_h1));
      if (out_valid) begin
        chk($signed(out_first) == exp_a[rd % QN], {exp_t[rd % QN], " first"},
            $signed(out_first), exp_a[rd % QN]);
        chk($signed(out_second) == exp_b[rd % QN], {exp_t[rd % QN], " second (R3)"},
            $signed(out_second), exp_b[rd % QN]);
        if (exp_t[rd % QN] == "R5" && $signed(out_first) == 2047)  hi_seen++;
        if (exp_t[rd % QN] == "R5" && $signed(out_first) == -2048) lo_seen++;
        rd++;
      end else begin
        chk(out_first == prev_a && out_second == prev_b, "R6 hold",
            int'(out_first), int'(prev_a));
      end
      en_h1  = in_en;
      prev_a = out_first;
      prev_b = out_second;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    chk(!out_valid && out_first == '0 && out_second == '0, "R1 reset state",
        int'(out_first), 0);
    rst <= 1'b0;

    // Table walk, with idle gaps carrying garbage data (R6)
    tag = "R4";
    for (int i = 0; i < STIM_N; i++) begin
      if (STIM[i] == IDLE) idle(2);
      else                 step(STIM[i]);
    end
    idle(4);

    // R3: lone sample appears on the second phase five steps later
    rst <= 1'b1; idle(2); clear_model(); rst <= 1'b0;
    tag = "R3";
    step(1234);
    for (int i = 0; i < 7; i++) step(0);
    idle(4);

    // R5: full-scale steps both ways
    tag = "R5";
    for (int i = 0; i < 12; i++) step(-2048);
    for (int i = 0; i < 12; i++) step(2047);
    for (int i = 0; i < 12; i++) step(-2048);
    idle(4);
    chk(hi_seen > 0, "R5 upper rail reached", hi_seen, 1);
    chk(lo_seen > 0, "R5 lower rail reached", lo_seen, 1);

    // R8: DC gain of both phases is unity
    tag = "R8";
    for (int i = 0; i < 14; i++) step(1000);
    idle(4);

    // R7: reset mid-stream, then history must be zero
    tag = "R7";
    for (int i = 0; i < 5; i++) step(1900 - i * 700);
    idle(4);
    rst <= 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!out_valid && out_first == '0 && out_second == '0, "R1 R7 reset clears",
        int'(out_first), 0);
    clear_model();
    rst <= 1'b0;
    @(negedge clk);
    chk(!out_valid && out_first == '0 && out_second == '0, "R1 after release",
        int'(out_second), 0);
    for (int i = 0; i < 8; i++) step(500);
    idle(4);

    chk(rd == wr, "R2 one pair per sample", rd, wr);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule